// File: doc/BRIEF.md
# SAR ADC Conversion Sequencer

This block is the digital sequencer and register set that sits in front of a successive-approximation converter. Software configures it over a small word-addressed bus. A conversion starts in one of three ways: a write to the control register, a pulse on a timer input, or automatically when the previous conversion ends. Each conversion has two parts. First there is an acquisition window of programmable length, during which the selected channel is routed to the sampler. Then there are RES_W bit-decision clocks, which resolve the code from the most significant bit down against a comparator input.

The finished code is written into a 32-bit data register in one clock edge. That same edge raises a ready flag and the converter's interrupt line. Both are cleared when software reads the data register.

A control write during a conversion abandons the conversion and starts a new one. A channel write never restarts anything. The new channel reaches the result only if it lands before acquisition ends.

Top module: `adc_conv_seq`

## Requirements
- R1: After reset, every register reads zero, and `adc_busy`, `sample_en`, `adc_irq` and `dac_code` are low.
- R2: The control register (word address 0) holds the start source in bits 2:0 and an acquisition field F in bits 4+ACQ_W-1:4. The start-source encodings are:
  - 000: stopped.
  - 001: start on each `timer_tick` pulse. Writing this value does not start a conversion.
  - 010: one conversion per control write.
  - 011: continuous. The write starts a conversion, and each completion starts the next acquisition.
  - Other values act as 000.
- R3: `adc_busy` rises on the edge that starts a conversion and stays high for exactly F+1+RES_W cycles. `sample_en` is high only during the first F+1 of those cycles.
- R4: The conversion decides one bit per clock from the MSB down. In each decision clock, `dac_code` equals the bits already kept plus the bit under test. The bit is kept when `cmp_in` is 1. An input whose level is V therefore converts to V.
- R5: On the edge that ends the last bit decision, three things happen together: the data register takes the new result, status bit 0 (ready) sets, and `adc_irq` sets.
- R6: A bus read of the data register clears ready and `adc_irq`. If that read falls on a completion edge, the completion wins.
- R7: A control write while busy does one of two things:
  - With an active source, it aborts the conversion, stores no result, and restarts acquisition with the newly written F.
  - With source 000, it drops `adc_busy` on that edge.
- R8: A channel-register write (word address 1, bits CH_W-1:0) never restarts a conversion and never changes the busy length.
- R9: The channel is latched on the edge that ends acquisition. A channel write registered before that edge gives a result from the new channel. A write registered during the decision phase leaves the result on the old channel.
- R10: Data-register layout (word address 2):
  - The result sits in bits 16+RES_W-1:16.
  - Bits CH_W-1:0 hold the channel that was converted. Software must mask them off.
  - All other bits are zero.
- R11: A `timer_tick` is ignored while busy, and it is ignored whenever the source is not 001.
- R12: The data register changes only on a completion edge. A read during a later conversion returns the last completed word.
- R13: Status register (word address 3): bit 0 is ready, bit 1 is busy, and all other bits are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access; drives read side effects |
| bus_addr | input | 2 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| timer_tick | input | 1 | One-cycle start pulse from a timer |
| cmp_in | input | 1 | Comparator decision: input at or above `dac_code` |
| dac_code | output | RES_W | Trial code for the current bit decision |
| adc_chan | output | CH_W | Channel routed to the sampler |
| sample_en | output | 1 | High during acquisition |
| adc_busy | output | 1 | High during acquisition and bit decisions |
| adc_irq | output | 1 | Raw converter interrupt line |

## Verification
The bench aims at the edges where timing rules meet:
- **Read on the completion edge.** A design that let the clear win would lose an interrupt.
- **Abort mid-acquisition.** A design that finished the old conversion, or kept the old acquisition length, would show the wrong busy length.
- **Channel writes just inside acquisition and just inside the decision phase.** A design that latched at the wrong point would tag and convert the wrong channel.
- **Tick during a conversion.** A design that did not ignore it would stretch the busy window.

The bench also reads the data register in the middle of a second conversion. A design that exposed a half-built result would return neither the old word nor the new one.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_ACQ  = 2'd1,
      PH_CONV = 2'd2
   } phase_e;

   localparam logic [2:0] SRC_OFF  = 3'b000;
   localparam logic [2:0] SRC_TICK = 3'b001;
   localparam logic [2:0] SRC_SW   = 3'b010;
   localparam logic [2:0] SRC_CONT = 3'b011;

   localparam logic [1:0] ADR_CTRL = 2'd0;
   localparam logic [1:0] ADR_CHAN = 2'd1;
   localparam logic [1:0] ADR_DATA = 2'd2;
   localparam logic [1:0] ADR_STAT = 2'd3;

   localparam int WORD_W   = 32;
   localparam int DATA_LSB = 16;
   localparam int ACQ_LSB  = 4;

   function automatic logic src_active(input logic [2:0] s);
      return (s == SRC_TICK) || (s == SRC_SW) || (s == SRC_CONT);
   endfunction

endpackage

// File: rtl/adc_seq_regs.sv
module adc_seq_regs
   import adc_seq_pkg::*;
#(
   parameter int RES_W = 12,
   parameter int CH_W  = 3,
   parameter int ACQ_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [1:0]        bus_addr,
   input  logic [WORD_W-1:0] bus_wdata,
   output logic [WORD_W-1:0] bus_rdata,
   input  logic              res_vld,
   input  logic [RES_W-1:0]  res_code,
   input  logic [CH_W-1:0]   res_ch,
   input  logic              busy,
   output logic              ctrl_wr,
   output logic [2:0]        cfg_src,
   output logic [ACQ_W-1:0]  cfg_acq,
   output logic [CH_W-1:0]   chan_sel,
   output logic              done
);

   logic [2:0]        src_q;
   logic [ACQ_W-1:0]  acq_q;
   logic [CH_W-1:0]   chan_q;
   logic [WORD_W-1:0] data_q;
   logic              done_q;
   logic              chan_wr;
   logic              data_rd;
   logic [WORD_W-1:0] res_word;
   logic [WORD_W-1:0] ctrl_word;
   logic              unused_wdata;

   initial begin
      assert (RES_W >= 2 && RES_W <= 14) else $error("RES_W out of range");
      assert (CH_W >= 1 && CH_W <= DATA_LSB) else $error("CH_W out of range");
      assert (ACQ_W >= 1 && ACQ_W + ACQ_LSB <= WORD_W) else $error("ACQ_W out of range");
   end

   assign unused_wdata = ^bus_wdata;

   assign ctrl_wr = bus_wr && (bus_addr == ADR_CTRL);
   assign chan_wr = bus_wr && (bus_addr == ADR_CHAN);
   assign data_rd = bus_rd && (bus_addr == ADR_DATA);

   // the write in flight takes effect for the start decision on this same edge
   assign cfg_src  = ctrl_wr ? bus_wdata[2:0] : src_q;
   assign cfg_acq  = ctrl_wr ? bus_wdata[ACQ_LSB +: ACQ_W] : acq_q;
   assign chan_sel = chan_q;
   assign done     = done_q;

   always_comb begin
      res_word = '0;
      res_word[DATA_LSB +: RES_W] = res_code;
      res_word[CH_W-1:0]          = res_ch;
      ctrl_word = '0;
      ctrl_word[2:0]              = src_q;
      ctrl_word[ACQ_LSB +: ACQ_W] = acq_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         src_q  <= SRC_OFF;
         acq_q  <= '0;
         chan_q <= '0;
      end else begin
         if (ctrl_wr) begin
            src_q <= bus_wdata[2:0];
            acq_q <= bus_wdata[ACQ_LSB +: ACQ_W];
         end
         if (chan_wr) chan_q <= bus_wdata[CH_W-1:0];
      end
   end

   // result lands whole in one edge; completion outranks the read clear
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_q <= '0;
         done_q <= 1'b0;
      end else begin
         if (res_vld) data_q <= res_word;
         if (res_vld)      done_q <= 1'b1;
         else if (data_rd) done_q <= 1'b0;
      end
   end

   always_comb begin
      unique case (bus_addr)
         ADR_CTRL: bus_rdata = ctrl_word;
         ADR_CHAN: bus_rdata = WORD_W'(chan_q);
         ADR_DATA: bus_rdata = data_q;
         default:  bus_rdata = {{(WORD_W-2){1'b0}}, busy, done_q};
      endcase
   end

   a_r5_done_on_result: assert property (@(posedge clk) disable iff (!rst_n)
      res_vld |=> done_q && (data_q[DATA_LSB +: RES_W] == $past(res_code)));

   a_r6_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
      data_rd && !res_vld |=> !done_q);

   a_r12_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !res_vld |=> $stable(data_q));

endmodule

// File: rtl/adc_seq_phase.sv
module adc_seq_phase
   import adc_seq_pkg::*;
#(
   parameter int RES_W = 12,
   parameter int CH_W  = 3,
   parameter int ACQ_W = 8,
   parameter int IDX_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ctrl_wr,
   input  logic [2:0]       cfg_src,
   input  logic [ACQ_W-1:0] cfg_acq,
   input  logic             timer_tick,
   input  logic [CH_W-1:0]  chan_sel,
   output phase_e           phase,
   output logic [IDX_W-1:0] bit_idx,
   output logic             conv_done,
   output logic [CH_W-1:0]  conv_ch,
   output logic [CH_W-1:0]  adc_chan,
   output logic             busy,
   output logic             sample_en
);

   localparam int CNT_W = (ACQ_W > IDX_W) ? ACQ_W : IDX_W;

   initial begin
      assert ((1 << IDX_W) >= RES_W) else $error("IDX_W too small for RES_W");
   end

   phase_e            phase_q, phase_d;
   logic [CNT_W-1:0]  cnt_q, cnt_d;
   logic [CH_W-1:0]   ch_q;
   logic              latch_ch;
   logic              last;
   logic              ctrl_go, ctrl_halt, tick_go;

   assign busy      = (phase_q != PH_IDLE);
   assign sample_en = (phase_q == PH_ACQ);
   assign last      = (cnt_q == '0);
   assign phase     = phase_q;
   assign bit_idx   = cnt_q[IDX_W-1:0];
   assign conv_ch   = ch_q;
   assign adc_chan  = (phase_q == PH_ACQ) ? chan_sel : ch_q;

   // an idle write of the tick source only arms; any active write while busy restarts
   assign ctrl_go   = ctrl_wr && src_active(cfg_src) && (busy || (cfg_src != SRC_TICK));
   assign ctrl_halt = ctrl_wr && !src_active(cfg_src);
   assign tick_go   = timer_tick && !busy && !ctrl_wr && (cfg_src == SRC_TICK);
   assign conv_done = (phase_q == PH_CONV) && last && !ctrl_wr;

   always_comb begin
      phase_d  = phase_q;
      cnt_d    = cnt_q;
      latch_ch = 1'b0;
      if (ctrl_halt) begin
         phase_d = PH_IDLE;
         cnt_d   = '0;
      end else if (ctrl_go || tick_go) begin
         phase_d = PH_ACQ;
         cnt_d   = CNT_W'(cfg_acq);
      end else begin
         unique case (phase_q)
            PH_ACQ: begin
               if (last) begin
                  phase_d  = PH_CONV;
                  cnt_d    = CNT_W'(RES_W - 1);
                  latch_ch = 1'b1;
               end else begin
                  cnt_d = cnt_q - 1'b1;
               end
            end
            PH_CONV: begin
               if (last) begin
                  if (cfg_src == SRC_CONT) begin
                     phase_d = PH_ACQ;
                     cnt_d   = CNT_W'(cfg_acq);
                  end else begin
                     phase_d = PH_IDLE;
                  end
               end else begin
                  cnt_d = cnt_q - 1'b1;
               end
            end
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
         cnt_q   <= '0;
         ch_q    <= '0;
      end else begin
         phase_q <= phase_d;
         cnt_q   <= cnt_d;
         if (latch_ch) ch_q <= chan_sel;
      end
   end

   a_r8_acq_countdown: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q == PH_ACQ) && !last && !ctrl_wr |=>
         (phase_q == PH_ACQ) && (cnt_q == $past(cnt_q) - 1'b1));

   a_r3_conv_runs: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q == PH_CONV) && !last && !ctrl_wr |=> (phase_q == PH_CONV));

   a_r9_chan_held: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q == PH_CONV) && !last && !ctrl_wr |=> $stable(adc_chan));

   a_r7_restart: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_wr && busy && src_active(cfg_src) |=>
         (phase_q == PH_ACQ) && (cnt_q == CNT_W'($past(cfg_acq))));

   a_r11_tick_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      timer_tick && busy && !ctrl_wr && !last |=> busy && (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/adc_seq_sar.sv
module adc_seq_sar #(
   parameter int RES_W = 12,
   parameter int IDX_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             conv_en,
   input  logic [IDX_W-1:0] bit_idx,
   input  logic             cmp_in,
   output logic [RES_W-1:0] dac_code,
   output logic [RES_W-1:0] res_code
);

   logic [RES_W-1:0] sar_q;
   logic [RES_W-1:0] trial;
   logic [RES_W-1:0] nxt;
   logic [RES_W-1:0] at_or_below;

   for (genvar b = 0; b < RES_W; b++) begin : g_bit
      logic hit;
      assign hit            = conv_en && (bit_idx == IDX_W'(b));
      assign trial[b]       = sar_q[b] | hit;
      assign nxt[b]         = hit ? cmp_in : sar_q[b];
      assign at_or_below[b] = (IDX_W'(b) <= bit_idx);
   end

   assign dac_code = trial;
   assign res_code = nxt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        sar_q <= '0;
      else if (!conv_en) sar_q <= '0;
      else               sar_q <= nxt;
   end

   a_r4_lower_undecided: assert property (@(posedge clk) disable iff (!rst_n)
      conv_en |-> ((sar_q & at_or_below) == '0));

   a_r4_single_trial: assert property (@(posedge clk) disable iff (!rst_n)
      conv_en |-> ($countones(dac_code ^ sar_q) == 1));

endmodule

// File: rtl/adc_conv_seq.sv
module adc_conv_seq
   import adc_seq_pkg::*;
#(
   parameter int RES_W = 12,
   parameter int CH_W  = 3,
   parameter int ACQ_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bus_wr,
   input  logic             bus_rd,
   input  logic [1:0]       bus_addr,
   input  logic [31:0]      bus_wdata,
   output logic [31:0]      bus_rdata,
   input  logic             timer_tick,
   input  logic             cmp_in,
   output logic [RES_W-1:0] dac_code,
   output logic [CH_W-1:0]  adc_chan,
   output logic             sample_en,
   output logic             adc_busy,
   output logic             adc_irq
);

   localparam int IDX_W = (RES_W > 1) ? $clog2(RES_W) : 1;

   logic             ctrl_wr;
   logic [2:0]       cfg_src;
   logic [ACQ_W-1:0] cfg_acq;
   logic [CH_W-1:0]  chan_sel;
   logic [CH_W-1:0]  conv_ch;
   logic [IDX_W-1:0] bit_idx;
   logic [RES_W-1:0] res_code;
   logic             conv_done;
   logic             busy;
   phase_e           phase;

   adc_seq_regs #(.RES_W(RES_W), .CH_W(CH_W), .ACQ_W(ACQ_W)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_wr    (bus_wr),
      .bus_rd    (bus_rd),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .res_vld   (conv_done),
      .res_code  (res_code),
      .res_ch    (conv_ch),
      .busy      (busy),
      .ctrl_wr   (ctrl_wr),
      .cfg_src   (cfg_src),
      .cfg_acq   (cfg_acq),
      .chan_sel  (chan_sel),
      .done      (adc_irq)
   );

   adc_seq_phase #(.RES_W(RES_W), .CH_W(CH_W), .ACQ_W(ACQ_W), .IDX_W(IDX_W)) u_phase (
      .clk        (clk),
      .rst_n      (rst_n),
      .ctrl_wr    (ctrl_wr),
      .cfg_src    (cfg_src),
      .cfg_acq    (cfg_acq),
      .timer_tick (timer_tick),
      .chan_sel   (chan_sel),
      .phase      (phase),
      .bit_idx    (bit_idx),
      .conv_done  (conv_done),
      .conv_ch    (conv_ch),
      .adc_chan   (adc_chan),
      .busy       (busy),
      .sample_en  (sample_en)
   );

   adc_seq_sar #(.RES_W(RES_W), .IDX_W(IDX_W)) u_sar (
      .clk      (clk),
      .rst_n    (rst_n),
      .conv_en  (phase == PH_CONV),
      .bit_idx  (bit_idx),
      .cmp_in   (cmp_in),
      .dac_code (dac_code),
      .res_code (res_code)
   );

   assign adc_busy = busy;

endmodule

// File: tb/adc_conv_seq_bench.sv
`timescale 1ns/1ps
module adc_conv_seq_bench;

   localparam int RES_W = 12;
   localparam int CH_W  = 3;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             bus_wr = 1'b0;
   logic             bus_rd = 1'b0;
   logic [1:0]       bus_addr = 2'd0;
   logic [31:0]      bus_wdata = 32'd0;
   logic [31:0]      bus_rdata;
   logic             timer_tick = 1'b0;
   logic             cmp_in;
   logic [RES_W-1:0] dac_code;
   logic [CH_W-1:0]  adc_chan;
   logic             sample_en, adc_busy, adc_irq;

   logic [RES_W-1:0] ana [8];

   int vectors = 0;
   int miscompares = 0;

   always #4 clk = ~clk;

   assign cmp_in = (ana[adc_chan] >= dac_code);

   adc_conv_seq u_adc_conv_seq (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .timer_tick(timer_tick), .cmp_in(cmp_in), .dac_code(dac_code),
      .adc_chan(adc_chan), .sample_en(sample_en), .adc_busy(adc_busy),
      .adc_irq(adc_irq)
   );

   task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
      vectors++;
      if (got !== exp) begin
         miscompares++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   function automatic logic [31:0] ctrl(input logic [2:0] src, input int f);
      return (32'(f) << 4) | 32'(src);
   endfunction

   function automatic logic [31:0] word(input logic [RES_W-1:0] v, input int ch);
      return (32'(v) << 16) | 32'(ch);
   endfunction

   task automatic bus_write(input logic [1:0] a, input logic [31:0] d);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic bus_read(input logic [1:0] a, output logic [31:0] d);
      bus_addr = a; bus_rd = 1'b1;
      #1 d = bus_rdata;
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic wait_idle(output int n);
      n = 0;
      while (adc_busy && n < 4000) begin
         @(negedge clk);
         n++;
      end
   endtask

   task automatic pulse_tick();
      timer_tick = 1'b1;
      @(negedge clk);
      timer_tick = 1'b0;
   endtask

   task automatic t_reset_state();
      logic [31:0] d;
      check("R1 busy", 32'(adc_busy), 0);
      check("R1 sample_en", 32'(sample_en), 0);
      check("R1 irq", 32'(adc_irq), 0);
      check("R1 dac_code", 32'(dac_code), 0);
      for (int a = 0; a < 4; a++) begin
         bus_read(2'(a), d);
         check($sformatf("R1 reg %0d", a), d, 0);
      end
   endtask

   task automatic t_single();
      logic [31:0] d;
      int n;
      ana[0] = 12'hA5C;
      bus_write(2'd1, 0);
      bus_write(2'd0, ctrl(3'b010, 3));
      check("R3 busy rises", 32'(adc_busy), 1);
      check("R3 sample_en in acquisition", 32'(sample_en), 1);
      idle(4);
      check("R3 sample_en low in decisions", 32'(sample_en), 0);
      wait_idle(n);
      check("R3 busy length", 32'(n + 4), 16);
      check("R5 irq on completion", 32'(adc_irq), 1);
      bus_read(2'd3, d);
      check("R13 status ready idle", d, 1);
      bus_read(2'd2, d);
      check("R10 data layout", d, word(12'hA5C, 0));
      check("R6 irq cleared by read", 32'(adc_irq), 0);
      bus_read(2'd3, d);
      check("R6 ready cleared", d, 0);
   endtask

   task automatic t_sar_patterns();
      logic [31:0] d;
      logic [RES_W-1:0] vals [5];
      int n;
      vals[0] = 12'h000; vals[1] = 12'hFFF; vals[2] = 12'h800;
      vals[3] = 12'h7FF; vals[4] = 12'h001;
      bus_write(2'd1, 5);
      for (int i = 0; i < 5; i++) begin
         ana[5] = vals[i];
         bus_write(2'd0, ctrl(3'b010, 0));
         wait_idle(n);
         check("R3 minimum acquisition length", 32'(n), 13);
         bus_read(2'd2, d);
         check("R4 code from MSB-first search", d, word(vals[i], 5));
      end
   endtask

   task automatic t_same_edge();
      logic [31:0] d;
      ana[5] = 12'h3C3;
      bus_write(2'd0, ctrl(3'b010, 3));
      idle(15);
      bus_read(2'd2, d);
      check("R12 old word before completion", d, word(12'h001, 5));
      check("R6 completion beats read", 32'(adc_irq), 1);
      check("R3 busy falls at completion", 32'(adc_busy), 0);
      bus_read(2'd2, d);
      check("R5 new result", d, word(12'h3C3, 5));
   endtask

   task automatic t_abort();
      logic [31:0] d;
      int n;
      ana[5] = 12'h2B7;
      bus_write(2'd0, ctrl(3'b010, 7));
      idle(5);
      bus_write(2'd0, ctrl(3'b010, 3));
      check("R7 still busy after restart", 32'(adc_busy), 1);
      wait_idle(n);
      check("R7 restart uses new length", 32'(n), 16);
      bus_read(2'd2, d);
      check("R7 single result after abort", d, word(12'h2B7, 5));
      bus_write(2'd0, ctrl(3'b010, 7));
      idle(3);
      bus_write(2'd0, ctrl(3'b000, 7));
      check("R7 stop write drops busy", 32'(adc_busy), 0);
      idle(20);
      check("R7 no result after stop", 32'(adc_irq), 0);
   endtask

   task automatic t_chan_acq();
      logic [31:0] d;
      int n;
      ana[1] = 12'h123; ana[2] = 12'h456;
      bus_write(2'd1, 1);
      bus_write(2'd0, ctrl(3'b010, 7));
      bus_write(2'd1, 2);
      wait_idle(n);
      check("R8 busy length with chan write", 32'(n + 1), 20);
      bus_read(2'd2, d);
      check("R9 acquisition change takes new channel", d, word(12'h456, 2));
   endtask

   task automatic t_chan_conv();
      logic [31:0] d;
      int n;
      bus_write(2'd1, 1);
      bus_write(2'd0, ctrl(3'b010, 3));
      idle(6);
      bus_write(2'd1, 2);
      wait_idle(n);
      check("R8 no restart in decisions", 32'(n + 7), 16);
      bus_read(2'd2, d);
      check("R9 decision-phase change keeps old channel", d, word(12'h123, 1));
   endtask

   task automatic t_tick();
      logic [31:0] d;
      int n;
      pulse_tick();
      check("R11 tick ignored in software mode", 32'(adc_busy), 0);
      ana[3] = 12'h9E1;
      bus_write(2'd1, 3);
      bus_write(2'd0, ctrl(3'b001, 3));
      check("R2 tick source write does not start", 32'(adc_busy), 0);
      pulse_tick();
      check("R2 tick starts conversion", 32'(adc_busy), 1);
      idle(5);
      pulse_tick();
      wait_idle(n);
      check("R11 tick while busy ignored", 32'(n + 6), 16);
      bus_read(2'd2, d);
      check("R2 tick result", d, word(12'h9E1, 3));
   endtask

   task automatic t_read_during();
      logic [31:0] d;
      int n;
      ana[6] = 12'h0F0;
      bus_write(2'd1, 6);
      bus_write(2'd0, ctrl(3'b010, 3));
      idle(8);
      bus_read(2'd2, d);
      check("R12 read mid-conversion returns last word", d, word(12'h9E1, 3));
      bus_read(2'd3, d);
      check("R13 status busy bit", d, 2);
      wait_idle(n);
      bus_read(2'd2, d);
      check("R12 new word after completion", d, word(12'h0F0, 6));
   endtask

   task automatic t_cont();
      logic [31:0] d;
      ana[4] = 12'h555;
      bus_write(2'd1, 4);
      bus_write(2'd0, ctrl(3'b011, 1));
      idle(14);
      check("R2 continuous first completion", 32'(adc_irq), 1);
      check("R2 continuous stays busy", 32'(adc_busy), 1);
      bus_read(2'd2, d);
      check("R2 continuous result", d, word(12'h555, 4));
      check("R6 irq cleared in continuous", 32'(adc_irq), 0);
      idle(13);
      check("R2 continuous second completion", 32'(adc_irq), 1);
      bus_write(2'd0, ctrl(3'b000, 0));
      check("R7 stop continuous", 32'(adc_busy), 0);
   endtask

   initial begin
      for (int i = 0; i < 8; i++) ana[i] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset_state();
      t_single();
      t_sar_patterns();
      t_same_edge();
      t_abort();
      t_chan_acq();
      t_chan_conv();
      t_tick();
      t_read_during();
      t_cont();
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      vectors++;
      miscompares++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

endmodule